// File: doc/BRIEF.md
# Banked Register File Decoder

This block sits between the operand-address field of a small microcontroller core and its data storage. The core supplies a 7-bit offset taken from the instruction word and a single bank-select bit taken from its status register. The block joins the two into an 8-bit effective address, decides which target owns that address, and steers the read and write strobes to it. Four targets exist: a port to the special-function registers (kept outside this block), a 96-byte general-purpose RAM behind bank 0, a separate 32-byte general-purpose RAM behind bank 1, and a 16-byte window at the top of bank 1 that reaches into the top of the bank-0 RAM instead of owning storage.

Reads are combinational: the selected byte appears on the read-data output in the same cycle that the offset and bank bit are presented. Writes to RAM commit on the rising clock edge when the write strobe is high, so a write followed by a read of the same location, through either of its two names, returns the new value one cycle later. Every address with no owner reads as zero and drops writes. The core's other status bits do not reach this block: only the bank bit is wired in, so reserved status bits cannot move the bank.

Top module: `banked_regfile`

## Requirements
- R1: The effective address is the bank bit in bit 7 above the 7-bit offset in bits 6:0, and it is driven on `sfr_addr_o` at all times.
- R2: Offsets 00h to 1Fh in either bank go to the special-function port: `sfr_rd_o` and `sfr_wr_o` follow `rd_i` and `wr_i`, and `rdata_o` equals `sfr_rdata_i`. At any other offset both port strobes stay low.
- R3: With the bank bit at 0, offsets 20h to 7Fh are RAM: a byte written there is returned by a later read of the same offset.
- R4: With the bank bit at 1, offsets 20h to 3Fh (effective A0h to BFh) are a second RAM, independent of bank-0 offsets 20h to 3Fh.
- R5: With the bank bit at 1, offsets 70h to 7Fh (effective F0h to FFh) reach the same bytes as bank-0 offsets 70h to 7Fh, for reads and writes in both directions. A write under one name is readable under the other in the next cycle.
- R6: With the bank bit at 1, offsets 40h to 6Fh (effective C0h to EFh) read as 00h, and a write there changes no RAM byte.
- R7: A RAM byte changes only on a rising clock edge with `wr_i` high. A cycle with `wr_i` low leaves it unchanged, whatever `wdata_i` carries.
- R8: While `rst` is high, `sfr_wr_o` stays low and RAM writes are blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; RAM writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| addr_i | input | 7 | Direct offset from the instruction word |
| bank_i | input | 1 | Bank-select bit from the status register |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed location, combinational |
| sfr_addr_o | output | 8 | Effective address presented to the special-function registers |
| sfr_rd_o | output | 1 | Read strobe to the special-function registers |
| sfr_wr_o | output | 1 | Write strobe to the special-function registers |
| sfr_wdata_o | output | 8 | Write data to the special-function registers |
| sfr_rdata_i | input | 8 | Read data returned by the special-function registers |

## Verification
A wrong decode shows at the ports in the same cycle as the address: a mis-steered read returns a RAM byte, zero or the special-function data where another was due, and a stray or missing strobe shows at once on the special-function port. A write sent to the wrong storage shows one cycle later, when a read of the intended location, or of its alias, returns the old byte. Reads of other locations show the damage. Each bank-0 and bank-1 RAM byte is written with a distinct pattern and read back after the unimplemented and aliased ranges have been written, so a misplaced write shows as a clash of patterns on the first read that reaches the affected byte.

// File: rtl/brf_pkg.sv
package brf_pkg;

  // Which storage owns the current effective address
  typedef enum logic [1:0] {
    TGT_SFR  = 2'd0,
    TGT_GPR0 = 2'd1,
    TGT_GPR1 = 2'd2,
    TGT_NONE = 2'd3
  } brf_tgt_e;

endpackage

// File: rtl/brf_addr_map.sv
module brf_addr_map
  import brf_pkg::*;
#(
  parameter int OFS_W    = 7,
  parameter int SFR_SPAN = 32,
  parameter int G0_LO    = 32,
  parameter int G1_LO    = 32,
  parameter int G1_SPAN  = 32,
  parameter int MIR_LO   = 112,
  parameter int G0_AW    = 7,
  parameter int G1_AW    = 5
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic             bank,
  output brf_tgt_e         tgt,
  output logic [G0_AW-1:0] g0_idx,
  output logic [G1_AW-1:0] g1_idx,
  output logic [OFS_W:0]   eff
);

  localparam logic [OFS_W-1:0] SFR_END_V = OFS_W'(SFR_SPAN);
  localparam logic [OFS_W-1:0] G0_LO_V   = OFS_W'(G0_LO);
  localparam logic [OFS_W-1:0] G1_LO_V   = OFS_W'(G1_LO);
  localparam logic [OFS_W-1:0] G1_END_V  = OFS_W'(G1_LO + G1_SPAN);
  localparam logic [OFS_W-1:0] MIR_LO_V  = OFS_W'(MIR_LO);

  logic [OFS_W-1:0] g0_rel;
  logic [OFS_W-1:0] g1_rel;

  // The alias window keeps the same offset, so the bank-0 index serves both names
  always_comb begin
    eff    = {bank, ofs};
    g0_rel = ofs - G0_LO_V;
    g1_rel = ofs - G1_LO_V;
    g0_idx = G0_AW'(g0_rel);
    g1_idx = G1_AW'(g1_rel);
    if (ofs < SFR_END_V) begin
      tgt = TGT_SFR;
    end else if (!bank) begin
      tgt = (ofs >= G0_LO_V) ? TGT_GPR0 : TGT_NONE;
    end else if ((ofs >= G1_LO_V) && (ofs < G1_END_V)) begin
      tgt = TGT_GPR1;
    end else if (ofs >= MIR_LO_V) begin
      tgt = TGT_GPR0;
    end else begin
      tgt = TGT_NONE;
    end
  end

endmodule

// File: rtl/brf_gpr_ram.sv
module brf_gpr_ram #(
  parameter int DEPTH = 96,
  parameter int DW    = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Write port on the clock edge; read port asynchronous (distributed RAM)
  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int OFS_W    = 7,
  parameter int DW       = 8,
  parameter int SFR_SPAN = 32,
  parameter int G0_LO    = 32,
  parameter int G1_LO    = 32,
  parameter int G1_SPAN  = 32,
  parameter int MIR_LO   = 112
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFS_W-1:0] addr_i,
  input  logic             bank_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [OFS_W:0]   sfr_addr_o,
  output logic             sfr_rd_o,
  output logic             sfr_wr_o,
  output logic [DW-1:0]    sfr_wdata_o,
  input  logic [DW-1:0]    sfr_rdata_i
);

  localparam int G0_DEPTH = (1 << OFS_W) - G0_LO;
  localparam int G0_AW    = $clog2(G0_DEPTH);
  localparam int G1_AW    = $clog2(G1_SPAN);

  brf_tgt_e         tgt;
  logic [G0_AW-1:0] g0_idx;
  logic [G1_AW-1:0] g1_idx;
  logic [OFS_W:0]   eff;
  logic             wr_ok;
  logic             g0_we;
  logic             g1_we;
  logic [DW-1:0]    g0_q;
  logic [DW-1:0]    g1_q;

  brf_addr_map #(
    .OFS_W   (OFS_W),
    .SFR_SPAN(SFR_SPAN),
    .G0_LO   (G0_LO),
    .G1_LO   (G1_LO),
    .G1_SPAN (G1_SPAN),
    .MIR_LO  (MIR_LO),
    .G0_AW   (G0_AW),
    .G1_AW   (G1_AW)
  ) u_map (
    .ofs   (addr_i),
    .bank  (bank_i),
    .tgt   (tgt),
    .g0_idx(g0_idx),
    .g1_idx(g1_idx),
    .eff   (eff)
  );

  assign wr_ok = wr_i && !rst;
  assign g0_we = wr_ok && (tgt == TGT_GPR0);
  assign g1_we = wr_ok && (tgt == TGT_GPR1);

  brf_gpr_ram #(.DEPTH(G0_DEPTH), .DW(DW), .AW(G0_AW)) u_gpr0 (
    .clk  (clk),
    .we   (g0_we),
    .idx  (g0_idx),
    .wdata(wdata_i),
    .rdata(g0_q)
  );

  brf_gpr_ram #(.DEPTH(G1_SPAN), .DW(DW), .AW(G1_AW)) u_gpr1 (
    .clk  (clk),
    .we   (g1_we),
    .idx  (g1_idx),
    .wdata(wdata_i),
    .rdata(g1_q)
  );

  // Special-function port
  assign sfr_addr_o  = eff;
  assign sfr_wdata_o = wdata_i;
  assign sfr_rd_o    = rd_i && (tgt == TGT_SFR);
  assign sfr_wr_o    = wr_ok && (tgt == TGT_SFR);

  always_comb begin
    unique case (tgt)
      TGT_SFR:  rdata_o = sfr_rdata_i;
      TGT_GPR0: rdata_o = g0_q;
      TGT_GPR1: rdata_o = g1_q;
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
  parameter int OFS_W    = 7,
  parameter int DW       = 8,
  parameter int SFR_SPAN = 32,
  parameter int G0_LO    = 32,
  parameter int G1_LO    = 32,
  parameter int G1_SPAN  = 32,
  parameter int MIR_LO   = 112
) (
  input logic             clk,
  input logic             rst,
  input logic [OFS_W-1:0] addr_i,
  input logic             bank_i,
  input logic             rd_i,
  input logic             wr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic             sfr_rd_o,
  input logic             sfr_wr_o,
  input logic [DW-1:0]    sfr_rdata_i
);

  localparam logic [OFS_W-1:0] SFR_END_V = OFS_W'(SFR_SPAN);
  localparam logic [OFS_W-1:0] G0_LO_V   = OFS_W'(G0_LO);
  localparam logic [OFS_W-1:0] G1_END_V  = OFS_W'(G1_LO + G1_SPAN);
  localparam logic [OFS_W-1:0] MIR_LO_V  = OFS_W'(MIR_LO);

  // R2: offsets past the special-function span never strobe the port
  a_r2_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
    (addr_i >= SFR_END_V) |-> (!sfr_rd_o && !sfr_wr_o));

  // R2: special-function span returns the port's data and mirrors the read strobe
  a_r2_sfr_passthru: assert property (@(posedge clk) disable iff (rst)
    (addr_i < SFR_END_V) |-> ((rdata_o == sfr_rdata_i) && (sfr_rd_o == rd_i)));

  // R3: bank-0 RAM returns the byte written in the previous cycle
  a_r3_b0_readback: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_i) && !$past(rst) && !$past(bank_i) && ($past(addr_i) >= G0_LO_V)
     && !bank_i && (addr_i == $past(addr_i))) |-> (rdata_o == $past(wdata_i)));

  // R5: top window is shared by both banks in both directions
  a_r5_alias_visible: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_i) && !$past(rst) && ($past(addr_i) >= MIR_LO_V)
     && (addr_i == $past(addr_i))) |-> (rdata_o == $past(wdata_i)));

  // R6: unowned bank-1 gap reads zero
  a_r6_gap_zero: assert property (@(posedge clk) disable iff (rst)
    (bank_i && (addr_i >= G1_END_V) && (addr_i < MIR_LO_V)) |-> (rdata_o == '0));

  // R8: no special-function write while reset is high
  always_comb begin
    if (rst) begin
      a_r8_reset_no_write: assert (!sfr_wr_o);
    end
  end

endmodule

bind banked_regfile brf_checker #(
  .OFS_W   (OFS_W),
  .DW      (DW),
  .SFR_SPAN(SFR_SPAN),
  .G0_LO   (G0_LO),
  .G1_LO   (G1_LO),
  .G1_SPAN (G1_SPAN),
  .MIR_LO  (MIR_LO)
) u_brf_checker (
  .clk        (clk),
  .rst        (rst),
  .addr_i     (addr_i),
  .bank_i     (bank_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .sfr_rd_o   (sfr_rd_o),
  .sfr_wr_o   (sfr_wr_o),
  .sfr_rdata_i(sfr_rdata_i)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] addr_i = '0;
  logic       bank_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] sfr_addr_o;
  logic       sfr_rd_o;
  logic       sfr_wr_o;
  logic [7:0] sfr_wdata_o;
  logic [7:0] sfr_rdata_i;

  always #10 clk = ~clk;

  // Stand-in special-function registers: return the inverted effective address
  assign sfr_rdata_i = ~sfr_addr_o;

  banked_regfile dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .bank_i(bank_i),
    .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sfr_addr_o(sfr_addr_o), .sfr_rd_o(sfr_rd_o), .sfr_wr_o(sfr_wr_o),
    .sfr_wdata_o(sfr_wdata_o), .sfr_rdata_i(sfr_rdata_i)
  );

  typedef struct {
    logic [7:0] exp;
    logic [7:0] ea;
    string      tag;
  } item_t;

  item_t      sb[$];
  int         n_vec = 0;
  int         n_bad = 0;
  logic [7:0] g0 [128];
  logic [7:0] g1 [32];

  function automatic logic [7:0] model_rd(logic [6:0] o, logic b);
    if (o < 7'h20) return ~{b, o};
    if (!b) return g0[o];
    if (o < 7'h40) return g1[o - 7'h20];
    if (o >= 7'h70) return g0[o];
    return 8'h00;
  endfunction

  function automatic void model_wr(logic [6:0] o, logic b, logic [7:0] d);
    if (o < 7'h20) return;
    if (!b) g0[o] = d;
    else if (o < 7'h40) g1[o - 7'h20] = d;
    else if (o >= 7'h70) g0[o] = d;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic drv_wr(logic [6:0] o, logic b, logic [7:0] d);
    @(negedge clk);
    addr_i = o; bank_i = b; wr_i = 1'b1; rd_i = 1'b0; wdata_i = d;
    if (!rst) model_wr(o, b, d);
  endtask

  task automatic drv_rd(logic [6:0] o, logic b, string tag);
    item_t it;
    @(negedge clk);
    addr_i = o; bank_i = b; wr_i = 1'b0; rd_i = 1'b1; wdata_i = 8'h00;
    it.exp = model_rd(o, b);
    it.ea  = {b, o};
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drv_idle();
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  // Monitor: compares read data a little after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " rdata"}, rdata_o, it.exp);
        check("R1 effective address", sfr_addr_o, it.ea);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R8: special-function write strobe held low during reset
    repeat (2) @(negedge clk);
    addr_i = 7'h04; bank_i = 1'b0; wr_i = 1'b1; wdata_i = 8'h99;
    #2 check("R8 sfr_wr_o in reset", {7'b0, sfr_wr_o}, 8'h00);
    @(negedge clk);
    rst = 1'b0; wr_i = 1'b0;

    // R3: fill bank 0; R4: fill bank 1 with a different pattern
    for (int o = 32; o < 128; o++) drv_wr(7'(o), 1'b0, 8'(o * 3 + 7));
    for (int o = 32; o < 64; o++)  drv_wr(7'(o), 1'b1, 8'(o) ^ 8'hA5);

    // R6: writes into the bank-1 gap must not land anywhere
    for (int o = 64; o < 112; o++) drv_wr(7'(o), 1'b1, 8'hFF);
    for (int o = 64; o < 112; o += 5) drv_rd(7'(o), 1'b1, "R6 gap reads zero");

    for (int o = 32; o < 128; o++) drv_rd(7'(o), 1'b0, "R3 bank0 ram");
    for (int o = 32; o < 64; o++)  drv_rd(7'(o), 1'b1, "R4 bank1 ram");

    // R5: alias both directions, read in the cycle right after the write
    drv_wr(7'h75, 1'b1, 8'hC3);
    drv_rd(7'h75, 1'b0, "R5 F5h write seen at 75h");
    drv_wr(7'h7A, 1'b0, 8'h3C);
    drv_rd(7'h7A, 1'b1, "R5 7Ah write seen at FAh");
    drv_rd(7'h70, 1'b1, "R5 F0h reads 70h");
    drv_rd(7'h7F, 1'b1, "R5 FFh reads 7Fh");

    // R7: strobe low with data present leaves the byte alone
    @(negedge clk);
    addr_i = 7'h40; bank_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0; wdata_i = 8'hEE;
    drv_rd(7'h40, 1'b0, "R7 no write without strobe");

    // R8: a write during a reset pulse is dropped
    drv_wr(7'h30, 1'b0, 8'h5A);
    @(negedge clk);
    rst = 1'b1; addr_i = 7'h30; bank_i = 1'b0; wr_i = 1'b1; wdata_i = 8'hEE;
    @(negedge clk);
    rst = 1'b0; wr_i = 1'b0;
    drv_rd(7'h30, 1'b0, "R8 write in reset blocked");

    // R2: special-function span in both banks
    drv_rd(7'h05, 1'b1, "R2 sfr read bank1");
    #2;
    check("R2 sfr_rd_o on read", {7'b0, sfr_rd_o}, 8'h01);
    check("R2 sfr_wr_o on read", {7'b0, sfr_wr_o}, 8'h00);
    drv_rd(7'h1F, 1'b0, "R2 sfr read bank0 top");
    drv_wr(7'h10, 1'b0, 8'h6B);
    #2;
    check("R2 sfr_wr_o on write", {7'b0, sfr_wr_o}, 8'h01);
    check("R2 sfr_wdata_o", sfr_wdata_o, 8'h6B);
    check("R1 sfr_addr_o on write", sfr_addr_o, 8'h10);
    drv_wr(7'h20, 1'b0, 8'h77);
    #2;
    check("R2 no strobe at 20h", {6'b0, sfr_rd_o, sfr_wr_o}, 8'h00);
    drv_rd(7'h20, 1'b0, "R3 write after sfr span");

    drv_idle();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule